// File: doc/BRIEF.md
# Latched-Input Byte-Writable Static Memory

A synthesizable model of a word-wide static memory whose address, chip select and write data each pass through a hold stage. While its enable is high, a hold stage is transparent and forwards its input. While its enable is low, it keeps the value it carried in the last sampled cycle before the enable fell. If both enables are tied high, the block acts as a plain memory with no input staging. If they are pulsed, the caller can release the address and data buses early, and the captured values still steer the access.

Each word is split into two 9-bit lanes, and each lane has its own active-low write strobe. Reads are combinational from the effective address. The output bus is paired with an output-enable flag that stands in for tri-state. The flag is low when the part is deselected, when either strobe is active, or when the output enable input is high.

The latches are modelled as registers sampled on `clk_i`. The memory array is written on the rising edge of `clk_i`. The address width is a parameter with a default of 10 bits. Setting it to 15 gives the full 32768-word array.

Top module: `latched_sram`

## Requirements
- R1: The array holds 2**ADDR_W words of 18 bits. A word written at an effective address is returned unchanged by a later read of that address.
- R2: While `addr_le_i` is high, the effective address and chip select follow `addr_i` and `ce_ni` in the same cycle.
- R3: While `addr_le_i` is low, the effective address and chip select are those sampled in the last clock cycle in which `addr_le_i` was high.
- R4: `data_le_i` high makes `din_i` the write data in the same cycle. While `data_le_i` is low, the write data is the `din_i` sampled in the last cycle in which `data_le_i` was high.
- R5: A rising clock edge with the part selected and `lwe_ni` low writes bits 8:0 only. Bits 17:9 of that word keep their value.
- R6: A rising clock edge with the part selected and `uwe_ni` low writes bits 17:9 only. Bits 8:0 keep their value.
- R7: With both strobes low, all 18 bits are written in one cycle.
- R8: When the effective chip select is high, no write happens and `dout_en_o` is low, whatever the other inputs are.
- R9: `dout_en_o` is high exactly when the part is selected, both strobes are high and `oe_ni` is low. `dout_o` then carries the word at the effective address.
- R10: During any write cycle, with either strobe low, `dout_en_o` is low.
- R11: Reset clears the held address and data and sets the held chip select to deselected. After reset, with `addr_le_i` low, the part stays deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock for the hold stages and the array |
| rst_ni | input | 1 | Active-low asynchronous reset of the hold stages |
| addr_i | input | ADDR_W | Word address |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| lwe_ni | input | 1 | Write strobe for bits 8:0, active low |
| uwe_ni | input | 1 | Write strobe for bits 17:9, active low |
| addr_le_i | input | 1 | Hold enable for address and chip select, high means transparent |
| data_le_i | input | 1 | Hold enable for write data, high means transparent |
| din_i | input | 18 | Write data |
| dout_o | output | 18 | Read data, zero when not driven |
| dout_en_o | output | 1 | High when the read data would be driven |

## Verification
The bench targets these corner cases:

- **Address changed after the hold stage closes.** The bench moves the address bus to another location while the address hold is closed. A design that forwarded the live bus would write to the wrong word and return the wrong data.
- **Data changed after the data hold closes.** The bench changes the data bus after the data hold has closed. A design that sampled too late would store the second value.
- **Single-lane writes.** The bench writes each lane on its own, then reads the whole word. A design with merged strobes would corrupt the other half.
- **Held chip select.** A deselect captured in the hold stage must keep the outputs off even while `ce_ni` is driven low. A design that forwarded `ce_ni` directly would raise `dout_en_o` or write memory there.

// File: rtl/lsram_pkg.sv
`timescale 1ns/1ps
package lsram_pkg;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned LANES  = 2;
  localparam int unsigned WORD_W = LANE_W * LANES;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_mask_t;
endpackage

// File: rtl/lsram_hold.sv
`timescale 1ns/1ps
module lsram_hold #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_q <= RST_VAL;
    else if (le_i) hold_q <= d_i;
  end

  // transparent while enabled, otherwise last captured value
  assign q_o = le_i ? d_i : hold_q;

  // R3
  hold_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_i |=> (le_i || q_o == $past(q_o)));
  // R2
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> (le_i || q_o == $past(d_i)));
endmodule

// File: rtl/lsram_lanes.sv
`timescale 1ns/1ps
module lsram_lanes
  import lsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  lane_mask_t        wr_i,
  input  word_t             wdata_i,
  output word_t             rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];

    // R5 R6: a lane without its strobe keeps its content
    lane_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i[g] |=> (addr_i != $past(addr_i) ||
                    rdata_o[g*LANE_W +: LANE_W] == $past(rdata_o[g*LANE_W +: LANE_W])));
  end
endmodule

// File: rtl/lsram_outctl.sv
`timescale 1ns/1ps
module lsram_outctl
  import lsram_pkg::*;
(
  input  logic       sel_ni,
  input  logic       oe_ni,
  input  lane_mask_t we_ni,
  input  word_t      rdata_i,
  output word_t      dout_o,
  output logic       dout_en_o
);
  logic drive;

  assign drive     = !sel_ni && (&we_ni) && !oe_ni;
  assign dout_en_o = drive;
  assign dout_o    = drive ? rdata_i : '0;
endmodule

// File: rtl/latched_sram.sv
`timescale 1ns/1ps
module latched_sram
  import lsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              lwe_ni,
  input  logic              uwe_ni,
  input  logic              addr_le_i,
  input  logic              data_le_i,
  input  logic [17:0]       din_i,
  output logic [17:0]       dout_o,
  output logic              dout_en_o
);
  localparam int unsigned AC_W = ADDR_W + 1;

  logic [AC_W-1:0] ac_eff;
  logic [ADDR_W-1:0] addr_eff;
  logic            sel_n_eff;
  word_t           wdata_eff;
  word_t           rdata;
  lane_mask_t      we_n;
  lane_mask_t      wr;

  // held chip select resets to deselected
  lsram_hold #(.W(AC_W), .RST_VAL({1'b1, {ADDR_W{1'b0}}})) u_addr_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .le_i  (addr_le_i),
    .d_i   ({ce_ni, addr_i}),
    .q_o   (ac_eff)
  );

  lsram_hold #(.W(WORD_W), .RST_VAL('0)) u_data_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .le_i  (data_le_i),
    .d_i   (din_i),
    .q_o   (wdata_eff)
  );

  assign sel_n_eff = ac_eff[ADDR_W];
  assign addr_eff  = ac_eff[ADDR_W-1:0];
  assign we_n      = {uwe_ni, lwe_ni};
  assign wr        = ~we_n & {LANES{~sel_n_eff}};

  lsram_lanes #(.ADDR_W(ADDR_W)) u_lanes (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_eff),
    .wr_i   (wr),
    .wdata_i(wdata_eff),
    .rdata_o(rdata)
  );

  lsram_outctl u_outctl (
    .sel_ni   (sel_n_eff),
    .oe_ni    (oe_ni),
    .we_ni    (we_n),
    .rdata_i  (rdata),
    .dout_o   (dout_o),
    .dout_en_o(dout_en_o)
  );

  // R8
  deselect_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_le_i && ce_ni) |-> !dout_en_o);
  // R10
  write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lwe_ni || !uwe_ni) |-> !dout_en_o);
  // R9
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dout_en_o);
  // R9
  read_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_le_i && !ce_ni && !oe_ni && lwe_ni && uwe_ni) |-> dout_en_o);
endmodule

// File: tb/latched_sram_test.sv
`timescale 1ns/1ps
module latched_sram_test;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_ni;
  logic [AW-1:0] addr;
  logic          ce_n, oe_n, lwe_n, uwe_n, ale, dle;
  logic [17:0]   din;
  logic [17:0]   dout;
  logic          dout_en;

  latched_sram #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .ce_ni(ce_n), .oe_ni(oe_n),
    .lwe_ni(lwe_n), .uwe_ni(uwe_n), .addr_le_i(ale), .data_le_i(dle),
    .din_i(din), .dout_o(dout), .dout_en_o(dout_en)
  );

  int    vectors = 0;
  int    errs    = 0;
  bit    done    = 0;
  string tag     = "R11";

  // reference state
  logic [8:0]    m_lo [DEPTH];
  logic [8:0]    m_hi [DEPTH];
  bit            k_lo [DEPTH];
  bit            k_hi [DEPTH];
  logic [AW-1:0] a_h;
  logic          c_h;
  logic [17:0]   d_h;

  task automatic drv(input logic [AW-1:0] a, input logic c, input logic o,
                     input logic lw, input logic uw, input logic al,
                     input logic dl, input logic [17:0] d);
    addr = a; ce_n = c; oe_n = o; lwe_n = lw; uwe_n = uw; ale = al; dle = dl; din = d;
  endtask

  // called just after a negedge with inputs set; compares, then advances one clock
  task automatic step();
    logic [AW-1:0] ea;
    logic          ec;
    logic [17:0]   ed;
    logic          en_x;
    #2;
    ea   = ale ? addr : a_h;
    ec   = ale ? ce_n : c_h;
    ed   = dle ? din  : d_h;
    en_x = !ec && lwe_n && uwe_n && !oe_n;
    vectors++;
    if (dout_en !== en_x) begin
      errs++;
      $display("FAIL %s dout_en_o got %b expected %b at %0t", tag, dout_en, en_x, $time);
    end else if (en_x && k_lo[ea] && k_hi[ea] && dout !== {m_hi[ea], m_lo[ea]}) begin
      errs++;
      $display("FAIL %s dout_o got %h expected %h at %0t", tag, dout, {m_hi[ea], m_lo[ea]}, $time);
    end
    @(posedge clk);
    if (!ec) begin
      if (!lwe_n) begin m_lo[ea] = ed[8:0];  k_lo[ea] = 1; end
      if (!uwe_n) begin m_hi[ea] = ed[17:9]; k_hi[ea] = 1; end
    end
    if (ale) begin a_h = addr; c_h = ce_n; end
    if (dle) d_h = din;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    drv(a, 0, 0, 1, 1, 1, 1, '0); step();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin k_lo[i] = 0; k_hi[i] = 0; end
    a_h = '0; c_h = 1'b1; d_h = '0;
    rst_ni = 1'b0;
    drv('0, 1, 1, 1, 1, 0, 0, '0);
    repeat (3) @(negedge clk);
    // R11: reset state
    #2; vectors++;
    if (dout_en !== 1'b0) begin
      errs++; $display("FAIL R11 dout_en_o got %b expected 0 in reset", dout_en);
    end
    @(negedge clk);
    rst_ni = 1'b1;
    // R11: held select stays deselected though ce_ni is low
    tag = "R11"; drv(7, 0, 0, 1, 1, 0, 0, '0); step();
    // R8: latched deselect blocks a write
    tag = "R8"; drv(7, 0, 0, 0, 0, 0, 1, 18'h3FFFF); step();

    // R1 R7 R2: transparent full write then read
    tag = "R7"; drv(5, 0, 0, 0, 0, 1, 1, 18'h2A5A5); step();
    tag = "R1"; rd(5);
    tag = "R2"; drv(6, 0, 0, 0, 0, 1, 1, 18'h13579); step(); rd(6); rd(5);
    // R5: lower lane only
    tag = "R5"; drv(5, 0, 0, 0, 1, 1, 1, 18'h3FFFF); step(); rd(5);
    // R6: upper lane only
    tag = "R6"; drv(6, 0, 0, 1, 0, 1, 1, 18'h00000); step(); rd(6);
    // R3: capture address 9, then move the bus away
    tag = "R3"; drv(9, 0, 1, 1, 1, 1, 1, '0); step();
    drv(3, 1, 0, 0, 0, 0, 1, 18'h1C3C3); step();
    rd(9); rd(3);
    drv(3, 1, 0, 1, 1, 0, 1, '0); step();
    // R4: capture data, then change the bus before the write
    tag = "R4"; drv(11, 0, 1, 1, 1, 1, 1, 18'h0BEEF); step();
    drv(11, 0, 1, 0, 0, 1, 0, 18'h3F00F); step(); rd(11);
    // R8: transparent deselect
    tag = "R8"; drv(11, 1, 0, 1, 1, 1, 1, '0); step();
    // R9: output enable high
    tag = "R9"; drv(11, 0, 1, 1, 1, 1, 1, '0); step();
    // R10: write with output enable low
    tag = "R10"; drv(12, 0, 0, 0, 1, 1, 1, 18'h00123); step();
    drv(12, 0, 0, 1, 0, 1, 1, 18'h2A000); step(); rd(12);

    // mixed traffic
    tag = "R1";
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      drv(AW'(r[3:0]), (r[7:4] == 4'h0), r[8], r[9] | r[10], r[11] | r[12],
          r[13] | r[14], r[15] | r[16], 18'($urandom));
      step();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errs++;
      $display("FAIL R1 watchdog got hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule